// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame should be kept, based only on its 48-bit destination address. The address arrives one byte per cycle, first byte first, after a start pulse that marks a new frame. While the bytes stream in, a byte-wide CRC-32 engine folds each byte into a running checksum and a shift register collects the full address.

One cycle after the sixth byte, a decision pulse is raised together with an accept flag. The decision depends on the filtering mode, a station address, and a 64-bit multicast hash table. Three modes are available: promiscuous mode keeps everything. All-multicast mode keeps every group frame and any frame that matches the station address exactly. Normal mode keeps exact matches and those group frames whose hash bit is set. Broadcast frames are always kept.

The table and the station address are written through a small 16-bit configuration port.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset `accept_valid` and `accept` are 0, every hash table bit is 0 and the station address is all zeros.
- R2: The hash of an address is bits [31:26] of a CRC-32 that starts at all ones. The CRC uses polynomial 0x04C11DB7 in the left-shifting form, takes the bits of each byte least significant first, in byte arrival order, and has no final inversion.
- R3: Hash value p selects table byte p[5:3] and bit p[2:0] within that byte. Configuration address k (0 to 3) holds table byte 2k in bits [7:0] and table byte 2k+1 in bits [15:8].
- R4: In normal mode (`mode` = 2'b00), a group frame (first address byte bit 0 set) that is not broadcast and does not match the station address is accepted exactly when its hash table bit is 1.
- R5: A frame whose destination equals the station address is accepted in every mode. Configuration addresses 4, 5 and 6 hold address bytes {0,1}, {2,3} and {4,5}, with the earlier byte in bits [15:8].
- R6: In normal and all-multicast modes, an individual frame (first byte bit 0 clear) that does not match the station address is rejected.
- R7: In all-multicast mode (`mode` = 2'b01), every group frame is accepted whatever the table holds.
- R8: When `mode[1]` is 1 (promiscuous), every frame is accepted.
- R9: The broadcast address (all ones) is accepted in every mode, even with an empty table.
- R10: `accept_valid` is a single-cycle pulse in the cycle after the sixth address byte is taken. `accept` is 0 whenever `accept_valid` is 0.
- R11: A start pulse discards any partial address and restarts the CRC. Bytes offered in the start cycle are ignored, and bytes after the sixth are ignored until the next start.
- R12: A configuration write to address 7 changes neither the table nor the station address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Marks the start of a new destination address |
| byte_valid | input | 1 | `byte_data` carries an address byte |
| byte_data | input | 8 | Destination address byte, first byte first |
| mode | input | 2 | 00 normal, 01 all-multicast, 1x promiscuous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | 0-3 hash words, 4-6 station words |
| cfg_wdata | input | 16 | Configuration write data |
| accept_valid | output | 1 | Decision pulse |
| accept | output | 1 | Keep the frame (valid with `accept_valid`) |

## Verification
A wrong CRC bit or a misplaced table bit has a visible effect at the ports. Group frames are then accepted or rejected against the wrong table entry, and the error shows on the decision pulse of the very frame that uses that entry. The bench therefore compares random tables and addresses against a separately computed hash. A stale byte counter or address register shows up differently: the decision pulse is missing or extra, or an exact match fails, and this is visible one cycle after the sixth byte of the next frame. Directed frames cover restarts in mid-address, bytes past the sixth, and the byte packing of both register groups.

// File: rtl/rx_dest_filter_pkg.sv
package rx_dest_filter_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = BYTE_W * ADDR_BYTES;
    localparam int CRC_W      = 32;
    localparam int HASH_W     = 6;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_SEED = '1;

    typedef enum logic [1:0] {
        FILT_NORMAL  = 2'b00,
        FILT_ALLMC   = 2'b01,
        FILT_PROMIS  = 2'b10,
        FILT_PROMIS2 = 2'b11
    } filt_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] dest;
        logic [HASH_W-1:0] hash;
        logic              done;
    } dest_info_t;

    // Fold one byte into the running checksum, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_fold_byte(
        input logic [CRC_W-1:0]  c_in,
        input logic [BYTE_W-1:0] d
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = c_in;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = c[CRC_W-1] ^ d[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/dest_crc_engine.sv
module dest_crc_engine
    import rx_dest_filter_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output dest_info_t        info
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    logic [CRC_W-1:0]  crc_q;
    logic [ADDR_W-1:0] dest_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;
    logic              take;

    assign take = byte_valid && !frame_start && (cnt_q <= LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q  <= CRC_SEED;
            dest_q <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (frame_start) begin
                crc_q  <= CRC_SEED;
                dest_q <= '0;
                cnt_q  <= '0;
            end else if (take) begin
                crc_q  <= crc_fold_byte(crc_q, byte_data);
                dest_q <= {dest_q[ADDR_W-BYTE_W-1:0], byte_data};
                cnt_q  <= cnt_q + 1'b1;
                done_q <= (cnt_q == LAST_IDX);
            end
        end
    end

    assign info.dest = dest_q;
    assign info.hash = crc_q[CRC_W-1 -: HASH_W];
    assign info.done = done_q;

endmodule

// File: rtl/dest_filter_regs.sv
module dest_filter_regs
    import rx_dest_filter_pkg::*;
#(
    parameter int REG_W     = 16,
    parameter int HASH_REGS = 4,
    parameter int CFG_AW    = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic [CFG_AW-1:0]          cfg_addr,
    input  logic [REG_W-1:0]           cfg_wdata,
    output logic [HASH_REGS*REG_W-1:0] table_bits,
    output logic [ADDR_W-1:0]          station
);
    localparam int STA_REGS = ADDR_W / REG_W;

    // Hash words: flat bit p lands in word p/REG_W, bit p%REG_W, which
    // places odd table bytes in the upper half of each word.
    for (genvar g = 0; g < HASH_REGS; g++) begin : g_hash
        logic [REG_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (cfg_we && cfg_addr == CFG_AW'(g))
                word_q <= cfg_wdata;
        end
        assign table_bits[g*REG_W +: REG_W] = word_q;
    end

    // Station words: earlier address byte in the upper half.
    for (genvar s = 0; s < STA_REGS; s++) begin : g_sta
        logic [REG_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (cfg_we && cfg_addr == CFG_AW'(HASH_REGS + s))
                word_q <= cfg_wdata;
        end
        assign station[ADDR_W-1-s*REG_W -: REG_W] = word_q;
    end

endmodule

// File: rtl/dest_match_decide.sv
module dest_match_decide
    import rx_dest_filter_pkg::*;
#(
    parameter int TBL_BITS = 64
) (
    input  dest_info_t          info,
    input  logic [TBL_BITS-1:0] table_bits,
    input  logic [ADDR_W-1:0]   station,
    input  filt_mode_e          mode,
    output logic                accept_valid,
    output logic                accept
);
    logic group, bcast, exact, hash_hit, keep;

    always_comb begin
        group    = info.dest[ADDR_W-BYTE_W];
        bcast    = &info.dest;
        exact    = (info.dest == station);
        hash_hit = table_bits[info.hash];
        unique case (mode)
            FILT_PROMIS, FILT_PROMIS2: keep = 1'b1;
            FILT_ALLMC:                keep = bcast | exact | group;
            default:                   keep = bcast | exact | (group & hash_hit);
        endcase
    end

    assign accept_valid = info.done;
    assign accept       = info.done & keep;

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rx_dest_filter_pkg::*;
#(
    parameter int REG_W     = 16,
    parameter int HASH_REGS = 4,
    parameter int CFG_AW    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic [1:0]        mode,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic              accept_valid,
    output logic              accept
);
    localparam int TBL_BITS = HASH_REGS * REG_W;

    dest_info_t           info;
    logic [TBL_BITS-1:0]  table_bits;
    logic [ADDR_W-1:0]    station;

    dest_crc_engine u_crc (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .info        (info)
    );

    dest_filter_regs #(
        .REG_W     (REG_W),
        .HASH_REGS (HASH_REGS),
        .CFG_AW    (CFG_AW)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .table_bits (table_bits),
        .station    (station)
    );

    dest_match_decide #(
        .TBL_BITS (TBL_BITS)
    ) u_decide (
        .info         (info),
        .table_bits   (table_bits),
        .station      (station),
        .mode         (filt_mode_e'(mode)),
        .accept_valid (accept_valid),
        .accept       (accept)
    );

endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk (
    input logic       clk,
    input logic       rst,
    input logic       frame_start,
    input logic       byte_valid,
    input logic [1:0] mode,
    input logic       accept_valid,
    input logic       accept
);
    // R10
    accept_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> accept_valid);

    // R10
    valid_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        accept_valid |=> !accept_valid);

    // R8
    promisc_keeps_all_chk: assert property (@(posedge clk) disable iff (rst)
        (accept_valid && mode[1]) |-> accept);

    // R11
    valid_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
        accept_valid |-> $past(byte_valid && !frame_start));

    // R11
    start_kills_valid_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !accept_valid);

endmodule

bind rx_dest_filter rx_dest_filter_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .byte_valid   (byte_valid),
    .mode         (mode),
    .accept_valid (accept_valid),
    .accept       (accept)
);

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [1:0]  mode = 2'b00;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        accept_valid, accept;

    int vectors = 0;
    int miscompares = 0;

    logic [63:0] m_tbl = '0;
    logic [47:0] m_sta = '0;

    always #4 clk = ~clk;

    rx_dest_filter u_dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .mode(mode), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .accept_valid(accept_valid), .accept(accept)
    );

    function automatic logic [5:0] ref_hash(input logic [47:0] d);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int b = 0; b < 6; b++) begin
            logic [7:0] x = d[47-8*b -: 8];
            for (int i = 0; i < 8; i++) begin
                logic top = c[31];
                c = c << 1;
                if (top ^ x[i]) c = c ^ 32'h04C11DB7;
            end
        end
        return c[31:26];
    endfunction

    function automatic logic ref_accept(input logic [47:0] d, input logic [1:0] m);
        if (m[1]) return 1'b1;
        if (&d || d == m_sta) return 1'b1;
        if (!d[40]) return 1'b0;
        if (m == 2'b01) return 1'b1;
        return m_tbl[ref_hash(d)];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 3'd4) m_tbl[a*16 +: 16] = d;
        else if (a < 3'd7) m_sta[47-(a-4)*16 -: 16] = d;
    endtask

    task automatic send_bytes(input logic [47:0] d, input int n);
        for (int i = 0; i < n; i++) begin
            byte_valid = 1'b1; byte_data = d[47-8*i -: 8];
            @(negedge clk);
        end
        byte_valid = 1'b0;
    endtask

    // Sends a full address; returns decision seen one cycle after byte six,
    // and checks that the pulse is gone a cycle later.
    task automatic frame(input logic [47:0] d, output logic v, output logic a);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        send_bytes(d, 6);
        v = accept_valid; a = accept;
        @(negedge clk);
        check("R10 pulse ends", accept_valid, 1'b0);
        check("R10 accept low without valid", accept, 1'b0);
    endtask

    task automatic frame_chk(input string req, input logic [47:0] d, input logic exp);
        logic v, a;
        frame(d, v, a);
        check(req, v, 1'b1);
        check(req, a, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [47:0] d;
        logic [5:0]  h;
        logic v, a;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 valid after reset", accept_valid, 1'b0);
        check("R1 accept after reset", accept, 1'b0);
        // R1 / R5: reset station is all zeros, so zero address matches
        frame_chk("R1 zero station", 48'h0, 1'b1);
        // R1 / R4: empty table rejects a group frame
        frame_chk("R1 empty table", 48'h0100_5E00_00FB, 1'b0);

        // R2 / R3: set exactly the hash bit of one address
        d = 48'h0100_5E00_00FB;
        h = ref_hash(d);
        wr(3'(h[5:4]), 16'(1) << h[3:0]);
        frame_chk("R2 hash bit hit", d, 1'b1);
        // R3: same word, other byte of the pair -> miss
        wr(3'(h[5:4]), 16'(1) << (h[3:0] ^ 4'd8));
        frame_chk("R3 byte pair placement", d, 1'b0);
        wr(3'(h[5:4]), 16'h0000);

        // R9: broadcast with empty table
        frame_chk("R9 broadcast normal", 48'hFFFF_FFFF_FFFF, 1'b1);
        // R7: all-multicast with empty table
        mode = 2'b01;
        frame_chk("R7 allmc group", 48'h3311_2233_4455, 1'b1);
        frame_chk("R6 allmc unicast miss", 48'h0211_2233_4455, 1'b0);
        // R8
        mode = 2'b10;
        frame_chk("R8 promisc unicast", 48'h0211_2233_4455, 1'b1);
        mode = 2'b00;

        // R5: station packing
        wr(3'd4, 16'h0A1B); wr(3'd5, 16'h2C3D); wr(3'd6, 16'h4E5F);
        frame_chk("R5 station match", 48'h0A1B_2C3D_4E5F, 1'b1);
        frame_chk("R5 station swapped bytes", 48'h1B0A_3D2C_5F4E, 1'b0);

        // R12: unmapped write changes nothing
        cfg_we = 1'b1; cfg_addr = 3'd7; cfg_wdata = 16'hFFFF;
        @(negedge clk);
        cfg_we = 1'b0;
        frame_chk("R12 table untouched", 48'h0100_5E00_00FB, 1'b0);
        frame_chk("R12 station untouched", 48'h0A1B_2C3D_4E5F, 1'b1);

        // R11: restart mid-address
        frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
        send_bytes(48'hFFFF_FFFF_FFFF, 3);
        frame_chk("R11 restart discards partial", 48'h0A1B_2C3D_4E5F, 1'b1);
        // R11: bytes past the sixth ignored
        send_bytes(48'hFFFF_FFFF_FFFF, 2);
        check("R11 extra bytes no pulse", accept_valid, 1'b0);
        @(negedge clk);
        check("R11 extra bytes no pulse later", accept_valid, 1'b0);
        // R11: byte in start cycle ignored
        frame_start = 1'b1; byte_valid = 1'b1; byte_data = 8'hEE;
        @(negedge clk);
        frame_start = 1'b0;
        send_bytes(48'h0A1B_2C3D_4E5F, 6);
        v = accept_valid; a = accept;
        check("R11 start cycle byte ignored", v, 1'b1);
        check("R11 start cycle byte ignored", a, 1'b1);
        @(negedge clk);

        // Random traffic
        for (int n = 0; n < 300; n++) begin
            int sel;
            string tag;
            if ($urandom_range(2) == 0) wr(3'($urandom_range(3)), 16'($urandom));
            if ($urandom_range(9) == 0) wr(3'($urandom_range(6, 4)), 16'($urandom));
            mode = 2'($urandom_range(3));
            sel = $urandom_range(7);
            d = {16'($urandom), $urandom};
            if (sel == 0) d = m_sta;
            else if (sel == 1) d = '1;
            else if (sel < 5) d[40] = 1'b1;
            if (mode[1]) tag = "R8 random";
            else if (&d) tag = "R9 random";
            else if (d == m_sta) tag = "R5 random";
            else if (!d[40]) tag = "R6 random";
            else if (mode == 2'b01) tag = "R7 random";
            else tag = "R4 random";
            frame_chk(tag, d, ref_accept(d, mode));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule